// File: doc/BRIEF.md
# Microprogram Sequencer with Multiway Branch and Return Stack

This block is the next-address engine of a microcoded control unit. It keeps the microprogram counter and holds the control store, which is a registered memory array. Every microinstruction it fetches carries three things: a branch-control field, a control-signal field and a target field. Each cycle the sequencer takes the current microinstruction and the status inputs and picks the next microaddress. It also reads that word out of the store, so the word for the new address is visible on the next cycle.

The branch-control field does two jobs. A 3-bit condition code decides whether the branch is taken. A 2-bit source select chooses the address offered when it is. That address can be the incremented counter, an opcode dispatch address, an external address, or the target field. A multiway flag ORs two case-select inputs into the target field, which gives a four-way jump in a single clock. Two of the condition codes are reserved for microsubroutines: one pushes the return address onto a small hardware stack, and the other pops it.

Synchronous reset forces the external address into the counter and empties the stack. An exception input also loads the external address but leaves the stack alone. The control store is filled through a plain write port, normally while reset is held.

Top module: `useq_top`

## Requirements
- R1: While `rst` is high, each clock edge loads `ext_addr` into `upc`, empties the return stack and clears `stk_err`. This takes priority over the exception input and over every branch decision.
- R2: With `rst` low and `exc` high, the edge loads `ext_addr` into `upc`. The branch-control field is ignored and the stack is not pushed or popped.
- R3: The microinstruction word is laid out as follows: target field in bits [AW-1:0], control-signal field in [AW+CW-1:AW], source select in [AW+CW+1:AW+CW], condition code in [AW+CW+4:AW+CW+2], multiway flag in [AW+CW+5]. Condition code 0 always advances `upc` to `upc`+1, wrapping modulo 2^AW.
- R4: Condition codes 1 to 5 mean always, N set, N clear, Z set and Z clear, tested against `n_flag` and `z_flag`. When the condition is false, the next address is `upc`+1.
- R5: When a branch is taken, the source select picks the next address: 0 gives `upc`+1, 1 gives `disp_addr`, 2 gives `ext_addr`, 3 gives the target field.
- R6: With the multiway flag set and source 3, the target is the target field with `case_sel` ORed into bits [3:2]. A target field whose bits [3:2] are zero therefore reaches the address ending in 00, 01, 10 or 11 in those bits within one clock.
- R7: Condition code 6 (call) always jumps to the selected source and pushes `upc`+1. The stack holds 4 entries, and a push onto a full stack discards the oldest entry.
- R8: Condition code 7 (return) loads `upc` from the most recently pushed entry and removes that entry (last in, first out).
- R9: A return on an empty stack loads address 0 and sets `stk_err`, which stays set until reset.
- R10: `ctrl` shows the control-signal field of the word stored at `upc`. `ctrl_active` is low exactly when that field is all zero. Such a word only tests and branches, and its branching works the same way.
- R11: When `wr_en` is high, an edge writes `wr_data` to `wr_addr`. A fetch of the same address at the same edge returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exc | input | 1 | Exception request (already synchronized) |
| n_flag | input | 1 | Negative status bit |
| z_flag | input | 1 | Zero status bit |
| case_sel | input | CASE_W | Case bits for the multiway branch |
| disp_addr | input | AW | Opcode dispatch address |
| ext_addr | input | AW | External address for reset and exception |
| wr_en | input | 1 | Control store write enable |
| wr_addr | input | AW | Control store write address |
| wr_data | input | WORD_W | Control store write data |
| upc | output | AW | Microprogram counter |
| ctrl | output | CW | Control-signal field of the current word |
| ctrl_active | output | 1 | Control-signal field is non-zero |
| stk_err | output | 1 | Sticky return-stack underflow flag |

## Verification
The bench goes after the stack edges. It runs five nested calls to overflow the stack, so a design that kept the oldest entry and dropped the newest would return to the wrong place. It then issues a return on an empty stack, where a design that fails to return 0 or to hold the error flag would show up at once. It drives four-way branches with every case value: placing the case bits at the wrong position, or adding them instead of ORing them, moves the jump target. It also raises exceptions in the same cycle as calls and returns, which catches a stack that moves when it should stay still. Finally, it writes to the address being fetched, which exposes a store that forwards new data instead of returning the old word.

// File: rtl/useq_pkg.sv
package useq_pkg;

  // Condition codes of the branch-control field
  typedef enum logic [2:0] {
    BC_NEXT   = 3'd0,
    BC_ALWAYS = 3'd1,
    BC_IF_N   = 3'd2,
    BC_IF_NN  = 3'd3,
    BC_IF_Z   = 3'd4,
    BC_IF_NZ  = 3'd5,
    BC_CALL   = 3'd6,
    BC_RET    = 3'd7
  } bcond_e;

  // Source offered when the branch is taken
  typedef enum logic [1:0] {
    SRC_INC   = 2'd0,
    SRC_DISP  = 2'd1,
    SRC_EXT   = 2'd2,
    SRC_FIELD = 2'd3
  } bsrc_e;

  localparam int COND_W = 3;
  localparam int SRC_W  = 2;

  // Whether a condition code wants the offered source
  function automatic logic cond_holds(bcond_e c, logic n, logic z);
    case (c)
      BC_ALWAYS, BC_CALL: return 1'b1;
      BC_IF_N:            return n;
      BC_IF_NN:           return !n;
      BC_IF_Z:            return z;
      BC_IF_NZ:           return !z;
      default:            return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store #(
  parameter int AW = 8,
  parameter int WW = 26,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rdata
);

  logic [WW-1:0] mem [DEPTH];

  // Registered read; a same-edge write is seen one fetch later
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/useq_stack.sv
module useq_stack #(
  parameter int AW    = 8,
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] top,
  output logic          empty,
  output logic          err
);

  logic [AW-1:0]    ent [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic             full;

  assign empty = (cnt == '0);
  assign full  = (cnt == CNT_W'(DEPTH));
  assign top   = empty ? '0 : ent[0];

  // Shift-register stack: entry 0 is the newest, the last entry falls off on overflow
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [AW-1:0] newer, older;
    if (i == 0) begin : g_first
      assign newer = din;
    end else begin : g_mid
      assign newer = ent[i-1];
    end
    if (i == DEPTH - 1) begin : g_last
      assign older = '0;
    end else begin : g_inner
      assign older = ent[i+1];
    end
    always_ff @(posedge clk) begin
      if (clr)       ent[i] <= '0;
      else if (push) ent[i] <= newer;
      else if (pop)  ent[i] <= older;
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt <= '0;
      err <= 1'b0;
    end else begin
      if (push && !full)      cnt <= cnt + 1'b1;
      else if (pop && !empty) cnt <= cnt - 1'b1;
      if (pop && empty)       err <= 1'b1;
    end
  end

  // R9
  // underflow_flag_chk
  underflow_flag_chk: assert property (@(posedge clk) disable iff (clr)
    (pop && empty) |=> err);

  // R9
  // err_sticky_chk
  err_sticky_chk: assert property (@(posedge clk) disable iff (clr)
    err |=> err);

  // R7
  // depth_bound_chk
  depth_bound_chk: assert property (@(posedge clk) disable iff (clr)
    cnt <= CNT_W'(DEPTH));

endmodule

// File: rtl/useq_nxt.sv
module useq_nxt
  import useq_pkg::*;
#(
  parameter int AW       = 8,
  parameter int CASE_LSB = 2,
  parameter int CASE_W   = 2
) (
  input  bcond_e            cond,
  input  bsrc_e             src,
  input  logic              mway,
  input  logic [AW-1:0]     field,
  input  logic [AW-1:0]     upc,
  input  logic [AW-1:0]     disp,
  input  logic [AW-1:0]     ext,
  input  logic [AW-1:0]     ret_addr,
  input  logic              n_flag,
  input  logic              z_flag,
  input  logic [CASE_W-1:0] case_sel,
  input  logic              force_ext,
  output logic [AW-1:0]     nxt,
  output logic [AW-1:0]     inc,
  output logic              taken,
  output logic              mway_hit,
  output logic              push,
  output logic              pop
);

  function automatic logic [AW-1:0] step_addr(logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  // ORs the case bits into the target at CASE_LSB
  function automatic logic [AW-1:0] fan_target(logic [AW-1:0] f,
                                               logic [CASE_W-1:0] cs,
                                               logic en);
    return en ? (f | (AW'(cs) << CASE_LSB)) : f;
  endfunction

  logic [AW-1:0] offered;

  assign inc      = step_addr(upc);
  assign mway_hit = mway && (src == SRC_FIELD);
  assign taken    = cond_holds(cond, n_flag, z_flag);
  assign push     = !force_ext && (cond == BC_CALL);
  assign pop      = !force_ext && (cond == BC_RET);

  always_comb begin
    case (src)
      SRC_DISP:  offered = disp;
      SRC_EXT:   offered = ext;
      SRC_FIELD: offered = fan_target(field, case_sel, mway);
      default:   offered = inc;
    endcase
  end

  always_comb begin
    if (force_ext)          nxt = ext;
    else if (cond == BC_RET) nxt = ret_addr;
    else if (taken)         nxt = offered;
    else                    nxt = inc;
  end

endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int AW       = 8,
  parameter int CW       = 12,
  parameter int DEPTH    = 4,
  parameter int CASE_LSB = 2,
  parameter int CASE_W   = 2,
  localparam int F_LSB   = 0,
  localparam int C_LSB   = AW,
  localparam int S_LSB   = AW + CW,
  localparam int B_LSB   = S_LSB + SRC_W,
  localparam int M_BIT   = B_LSB + COND_W,
  localparam int WORD_W  = M_BIT + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exc,
  input  logic              n_flag,
  input  logic              z_flag,
  input  logic [CASE_W-1:0] case_sel,
  input  logic [AW-1:0]     disp_addr,
  input  logic [AW-1:0]     ext_addr,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [AW-1:0]     upc,
  output logic [CW-1:0]     ctrl,
  output logic              ctrl_active,
  output logic              stk_err
);

  logic [WORD_W-1:0] mir;
  logic [AW-1:0]     nxt, inc, ret_addr, field;
  logic              force_ext, taken, mway_hit, push, pop, stk_empty;
  bcond_e            cond;
  bsrc_e             src;

  assign force_ext   = rst || exc;
  assign field       = mir[F_LSB +: AW];
  assign ctrl        = mir[C_LSB +: CW];
  assign src         = bsrc_e'(mir[S_LSB +: SRC_W]);
  assign cond        = bcond_e'(mir[B_LSB +: COND_W]);
  assign ctrl_active = |ctrl;

  useq_store #(.AW(AW), .WW(WORD_W)) u_store (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (nxt),
    .rdata (mir)
  );

  useq_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
    .clk   (clk),
    .clr   (rst),
    .push  (push),
    .pop   (pop),
    .din   (inc),
    .top   (ret_addr),
    .empty (stk_empty),
    .err   (stk_err)
  );

  useq_nxt #(.AW(AW), .CASE_LSB(CASE_LSB), .CASE_W(CASE_W)) u_nxt (
    .cond      (cond),
    .src       (src),
    .mway      (mir[M_BIT]),
    .field     (field),
    .upc       (upc),
    .disp      (disp_addr),
    .ext       (ext_addr),
    .ret_addr  (ret_addr),
    .n_flag    (n_flag),
    .z_flag    (z_flag),
    .case_sel  (case_sel),
    .force_ext (force_ext),
    .nxt       (nxt),
    .inc       (inc),
    .taken     (taken),
    .mway_hit  (mway_hit),
    .push      (push),
    .pop       (pop)
  );

  always_ff @(posedge clk) begin
    upc <= nxt;
  end

  // R1
  // reset_load_chk
  reset_load_chk: assert property (@(posedge clk)
    rst |=> (upc == $past(ext_addr)));

  // R2
  // exc_load_chk
  exc_load_chk: assert property (@(posedge clk) disable iff (rst)
    exc |=> (upc == $past(ext_addr)));

  // R3
  // seq_step_chk
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!exc && cond == BC_NEXT) |=> (upc == AW'($past(upc) + 1'b1)));

  // R6
  // mway_case_chk
  mway_case_chk: assert property (@(posedge clk) disable iff (rst)
    (!exc && taken && mway_hit && cond != BC_RET) |=>
      (upc[CASE_LSB +: CASE_W] ==
       ($past(field[CASE_LSB +: CASE_W]) | $past(case_sel))));

  // R2
  // exc_stack_hold_chk
  exc_stack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    exc |-> (!push && !pop));

  // R9
  // empty_return_chk
  empty_return_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && stk_empty) |=> (upc == '0));

endmodule

// File: tb/useq_top_tb.sv
module useq_top_tb;

  localparam int AW = 8;
  localparam int CW = 12;
  localparam int WW = 26;
  localparam int NA = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          exc = 1'b0;
  logic          n_flag = 1'b0, z_flag = 1'b0;
  logic [1:0]    case_sel = '0;
  logic [AW-1:0] disp_addr = '0, ext_addr = 8'h10;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [WW-1:0] wr_data = '0;
  logic [AW-1:0] upc;
  logic [CW-1:0] ctrl;
  logic          ctrl_active, stk_err;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  useq_top u_dut (
    .clk(clk), .rst(rst), .exc(exc), .n_flag(n_flag), .z_flag(z_flag),
    .case_sel(case_sel), .disp_addr(disp_addr), .ext_addr(ext_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .upc(upc), .ctrl(ctrl), .ctrl_active(ctrl_active), .stk_err(stk_err)
  );

  // Bench model state
  logic [WW-1:0] mem_m [NA];
  logic [AW-1:0] upc_m;
  logic [AW-1:0] stk_m [4];
  int            cnt_m;
  logic          err_m;

  function automatic logic [WW-1:0] mk(int cond, int src, bit mw, int c, int f);
    return {mw, 3'(cond), 2'(src), 12'(c), 8'(f)};
  endfunction

  // Directed image: five nested calls, returns, an empty return, then a four-way branch
  function automatic bit directed(int a, output logic [WW-1:0] w);
    w = '0;
    case (a)
      8'h10: begin w = mk(6, 3, 0, 12'h001, 8'h20); return 1; end
      8'h20: begin w = mk(6, 3, 0, 12'h002, 8'h30); return 1; end
      8'h30: begin w = mk(6, 3, 0, 12'h004, 8'h40); return 1; end
      8'h40: begin w = mk(6, 3, 0, 12'h008, 8'h50); return 1; end
      8'h50: begin w = mk(6, 3, 0, 12'h010, 8'h60); return 1; end
      8'h60, 8'h51, 8'h41, 8'h31, 8'h21:
             begin w = mk(7, 0, 0, 12'h020, 8'h00); return 1; end
      8'h00: begin w = mk(1, 3, 1, 12'h000, 8'h80); return 1; end
      8'h80, 8'h84, 8'h88, 8'h8C:
             begin w = mk(1, 1, 0, 12'h000, 8'h00); return 1; end
      default: return 0;
    endcase
  endfunction

  function automatic logic [WW-1:0] rand_word();
    int c;
    c = ($urandom % 4 == 0) ? 0 : int'($urandom % 4096);
    return mk(int'($urandom % 8), int'($urandom % 4), 1'($urandom % 2), c,
              int'($urandom % NA));
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One clock: compute expectations from the requirements, clock, compare
  task automatic cycle();
    logic [WW-1:0] w;
    logic [AW-1:0] fld, inc, offer, e_next;
    int            cond, src;
    bit            mw, tk;
    string         tag;
    w    = mem_m[upc_m];
    fld  = w[7:0];
    src  = int'(w[21:20]);
    cond = int'(w[24:22]);
    mw   = w[25];
    inc  = upc_m + 8'd1;
    case (src)
      0: offer = inc;
      1: offer = disp_addr;
      2: offer = ext_addr;
      default: offer = mw ? (fld | {4'b0, case_sel, 2'b00}) : fld;
    endcase
    case (cond)
      1, 6: tk = 1;
      2: tk = n_flag;
      3: tk = !n_flag;
      4: tk = z_flag;
      5: tk = !z_flag;
      default: tk = 0;
    endcase
    if (rst) begin
      tag = "R1"; e_next = ext_addr;
      cnt_m = 0; err_m = 0;
      for (int i = 0; i < 4; i++) stk_m[i] = '0;
    end else if (exc) begin
      tag = "R2"; e_next = ext_addr;
    end else if (cond == 7) begin
      if (cnt_m == 0) begin
        tag = "R9"; e_next = '0; err_m = 1;
      end else begin
        tag = "R8"; e_next = stk_m[0];
        for (int i = 0; i < 3; i++) stk_m[i] = stk_m[i+1];
        stk_m[3] = '0; cnt_m--;
      end
    end else if (cond == 6) begin
      tag = "R7"; e_next = offer;
      for (int i = 3; i > 0; i--) stk_m[i] = stk_m[i-1];
      stk_m[0] = inc;
      if (cnt_m < 4) cnt_m++;
    end else if (cond == 0) begin
      tag = "R3"; e_next = inc;
    end else if (tk) begin
      tag = (src == 3 && mw) ? "R6" : "R5"; e_next = offer;
    end else begin
      tag = "R4"; e_next = inc;
    end
    // expected word fetched before this edge's write lands
    w = mem_m[e_next];
    if (wr_en) mem_m[wr_addr] = wr_data;
    @(posedge clk);
    #1;
    upc_m = e_next;
    chk(upc == e_next, tag, "upc", int'(upc), int'(e_next));
    chk(ctrl == w[19:8] && ctrl_active == (w[19:8] != '0),
        (wr_en && wr_addr == e_next) ? "R11" : "R10", "ctrl",
        int'({ctrl_active, ctrl}), int'({(w[19:8] != '0), w[19:8]}));
    chk(stk_err == err_m, "R9", "stk_err", int'(stk_err), int'(err_m));
  endtask

  task automatic load_image(bit use_directed);
    logic [WW-1:0] w;
    rst = 1'b1; exc = 1'b0; ext_addr = 8'h10;
    for (int a = 0; a < NA; a++) begin
      @(negedge clk);
      if (!(use_directed && directed(a, w))) w = rand_word();
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = w;
      cycle();
    end
    @(negedge clk);
    wr_en = 1'b0;
    cycle();
    // R11: rewrite the word being fetched; old word first, new word next
    @(negedge clk);
    w = mem_m[8'h10];
    wr_en = 1'b1; wr_addr = 8'h10; wr_data = {w[25:20], 12'hA5A, w[7:0]};
    cycle();
    chk(ctrl != 12'hA5A || w[19:8] == 12'hA5A, "R11", "old word on collision",
        int'(ctrl), int'(w[19:8]));
    @(negedge clk);
    wr_en = 1'b0;
    cycle();
    chk(ctrl == 12'hA5A, "R11", "new word after write", int'(ctrl), 12'hA5A);
    // R1: reset state
    chk(upc == 8'h10 && stk_err == 1'b0, "R1", "reset state",
        int'({stk_err, upc}), 8'h10);
  endtask

  task automatic run(int n, int quiet);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rst       = 1'b0;
      wr_en     = 1'b0;
      n_flag    = 1'($urandom % 2);
      z_flag    = 1'($urandom % 2);
      case_sel  = 2'($urandom % 4);
      disp_addr = AW'($urandom % NA);
      ext_addr  = AW'($urandom % NA);
      exc       = (k >= quiet) && ($urandom % 32 == 0);
      cycle();
    end
  endtask

  initial begin
    void'($urandom(32'h5EC0_0D1E));
    for (int i = 0; i < 4; i++) stk_m[i] = '0;
    cnt_m = 0; err_m = 0; upc_m = '0;
    // Directed image: overflow of the stack, empty return, four-way branch
    load_image(1);
    run(40, 40);
    chk(stk_err == 1'b1, "R9", "sticky after empty return", int'(stk_err), 1);
    // R6: each case value from the four-way entry
    for (int cs = 0; cs < 4; cs++) begin
      @(negedge clk);
      rst = 1'b1; ext_addr = 8'h00; exc = 1'b0;
      cycle();
      @(negedge clk);
      rst = 1'b0; case_sel = 2'(cs);
      cycle();
      chk(upc == AW'(8'h80 | (cs << 2)), "R6", "four-way target",
          int'(upc), 8'h80 | (cs << 2));
    end
    run(1500, 0);
    for (int r = 0; r < 3; r++) begin
      load_image(0);
      run(2500, 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule